// File: doc/BRIEF.md
# Transmitter analog-setting window

This block gives a host indirect access to per-lane transmitter analog settings through a five-word register window. The host selects a lane and a link-port number, picks one analog parameter with a selector register, and puts a value in a staging register. It then writes a one-shot command bit to start a store or a fetch. The parameter values themselves live in a local shadow table, one entry for each parameter on each lane.

Each accepted command keeps the block busy for a fixed number of cycles. This models the latency of the physical update path. At the end of a fetch, the staging register holds the stored value, zero-extended. Before a command starts, the block checks the lane, port and selector values. If any of them is out of range, it raises an error flag and does not run the command.

The three parameters are: an unsigned 6-bit output swing, a 5-bit sign-magnitude pre-cursor emphasis with two codes for zero, and an unsigned 5-bit first post-cursor emphasis.

Top module: `tx_analog_cfg_win`

## Requirements
- R1: After reset, every register reads zero. Busy and error are low, and every stored parameter on every lane is zero.
- R2: Register map, by word address:
  - 0x08: lane number, 8 bits, read-write.
  - 0x09: port number, 8 bits, read-write.
  - 0x0A: command/status. Bit 9 reads the error flag and bit 8 reads the busy flag. Bits 0 and 1 are command bits and always read zero.
  - 0x0B: parameter selector, 6 bits, read-write.
  - 0x0C: staging value, 7 bits, read-write.
  
  Undefined bits and unmapped addresses read zero, and writes to them change nothing.
- R3: Writing 0x0A with bit 0 set starts a store of the staging value into the selected parameter. Writing it with bit 1 set starts a fetch. If both bits are set, the store wins.
- R4: An accepted command raises busy from the cycle after the command write. Busy stays high for exactly 4 cycles, and the result is visible when busy falls.
- R5: A command is rejected when the lane number is 4 or more, the port number is 2 or more, or the selector is above 2. A rejected command sets the error flag, does not raise busy, and leaves every stored parameter unchanged. Any accepted command clears the error flag.
- R6: While busy is high, command writes are ignored. Writes to the lane, port, selector and staging registers are also ignored.
- R7: Selector 0 is output swing. A store keeps staging bits [5:0], and bit 6 is ignored.
- R8: Selector 1 is pre-cursor emphasis, 5-bit sign-magnitude. A store keeps staging bits [4:0] exactly as written, so the codes 0x00 and 0x10 stay distinct. Bits [6:5] are ignored.
- R9: Selector 2 is post-cursor emphasis. A store keeps staging bits [4:0], unsigned.
- R10: When a fetch completes, the staging register holds the stored parameter in its low bits, with the unused upper bits zero.
- R11: Each lane keeps its own copy of each parameter. A store on one lane does not change any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest case to reach from the ports is a host access that lands while a command is still in flight. Examples are a second command, or a rewrite of the staging value, arriving in the middle of the busy window. Another is the cycle where busy falls, because there the fetch result and a host write could compete for the staging register.

The stimulus starts a store and then fires a fetch command and a staging write on the next cycles, while busy is known to be high. The reference model applies the same bus traffic cycle by cycle. Comparing every register read on every clock exposes any access that leaks through.

// File: rtl/tx_analog_cfg_win.sv
module tx_analog_cfg_win #(
  parameter int NUM_LANE  = 4,
  parameter int NUM_PORT  = 2,
  parameter int OP_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int LANE_W = (NUM_LANE > 1) ? $clog2(NUM_LANE) : 1;
  localparam int CNT_W  = $clog2(OP_CYCLES + 1);
  localparam logic [7:0] LANE_LIM = 8'(NUM_LANE);
  localparam logic [7:0] PORT_LIM = 8'(NUM_PORT);
  localparam logic [6:0] A_LANE = 7'h08;
  localparam logic [6:0] A_PORT = 7'h09;
  localparam logic [6:0] A_CMD  = 7'h0A;
  localparam logic [6:0] A_SEL  = 7'h0B;
  localparam logic [6:0] A_VAL  = 7'h0C;

  logic [7:0]       lane_q, port_q;
  logic [5:0]       sel_q;
  logic [6:0]       val_q;
  logic             busy_q, err_q, op_store_q;
  logic [CNT_W-1:0] cnt_q;

  logic [5:0] swing_q [NUM_LANE];
  logic [4:0] pre_q   [NUM_LANE];
  logic [4:0] post_q  [NUM_LANE];

  logic              cmd, bad, done;
  logic [LANE_W-1:0] lane_idx;
  logic [6:0]        fetched;

  assign cmd      = bus_wr && bus_addr == A_CMD && (bus_wdata[0] || bus_wdata[1]) && !busy_q;
  assign bad      = lane_q >= LANE_LIM || port_q >= PORT_LIM || sel_q > 6'd2;
  assign done     = busy_q && cnt_q == '0;
  assign lane_idx = lane_q[LANE_W-1:0];

  always_comb begin
    case (sel_q)
      6'd0:    fetched = {1'b0, swing_q[lane_idx]};
      6'd1:    fetched = {2'b0, pre_q[lane_idx]};
      6'd2:    fetched = {2'b0, post_q[lane_idx]};
      default: fetched = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q     <= '0;
      port_q     <= '0;
      sel_q      <= '0;
      val_q      <= '0;
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      op_store_q <= 1'b0;
      cnt_q      <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        if (!op_store_q) val_q <= fetched;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      if (bus_wr && bus_addr == A_LANE) lane_q <= bus_wdata[7:0];
      if (bus_wr && bus_addr == A_PORT) port_q <= bus_wdata[7:0];
      if (bus_wr && bus_addr == A_SEL)  sel_q  <= bus_wdata[5:0];
      if (bus_wr && bus_addr == A_VAL)  val_q  <= bus_wdata[6:0];
      if (cmd) begin
        err_q <= bad;
        if (!bad) begin
          busy_q     <= 1'b1;
          cnt_q      <= CNT_W'(OP_CYCLES - 1);
          op_store_q <= bus_wdata[0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LANE; i++) begin
        swing_q[i] <= '0;
        pre_q[i]   <= '0;
        post_q[i]  <= '0;
      end
    end else if (done && op_store_q) begin
      case (sel_q)
        6'd0:    swing_q[lane_idx] <= val_q[5:0];
        6'd1:    pre_q[lane_idx]   <= val_q[4:0];
        6'd2:    post_q[lane_idx]  <= val_q[4:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LANE:  bus_rdata[7:0] = lane_q;
      A_PORT:  bus_rdata[7:0] = port_q;
      A_CMD:   bus_rdata[9:8] = {err_q, busy_q};
      A_SEL:   bus_rdata[5:0] = sel_q;
      A_VAL:   bus_rdata[6:0] = val_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/tx_analog_cfg_win_chk.sv
module tx_analog_cfg_win_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        busy,
  input logic        err,
  input logic [5:0]  sel
);
  p_busy_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy);

  p_err_no_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  p_bad_sel_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 7'h0A && bus_wdata[1:0] != 2'b00 && !busy && sel > 6'd2)
      |=> err && !busy);

  p_sel_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 7'h0B && busy) |=> $stable(sel));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:10] == 22'd0);
endmodule

bind tx_analog_cfg_win tx_analog_cfg_win_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .busy(busy_q), .err(err_q), .sel(sel_q)
);

// File: tb/test_tx_analog_cfg_win.sv
module test_tx_analog_cfg_win;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tx_analog_cfg_win i_tx_analog_cfg_win (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // behavioural reference model
  int m_lane, m_port, m_sel, m_val, m_busy, m_left, m_err, m_store;
  int m_swing[4], m_pre[4], m_post[4];
  int was_busy;

  function automatic int model_read(int a);
    case (a)
      8:  return m_lane;
      9:  return m_port;
      10: return m_err * 512 + m_busy * 256;
      11: return m_sel;
      12: return m_val;
      default: return 0;
    endcase
  endfunction

  function automatic int model_param();
    if (m_sel == 0) return m_swing[m_lane];
    if (m_sel == 1) return m_pre[m_lane];
    return m_post[m_lane];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lane = 0; m_port = 0; m_sel = 0; m_val = 0;
      m_busy = 0; m_left = 0; m_err = 0; m_store = 0;
      for (int i = 0; i < 4; i++) begin m_swing[i] = 0; m_pre[i] = 0; m_post[i] = 0; end
    end else begin
      was_busy = m_busy;
      if (was_busy != 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 0;
          if (m_store != 0) begin
            if (m_sel == 0) m_swing[m_lane] = m_val % 64;
            else if (m_sel == 1) m_pre[m_lane] = m_val % 32;
            else m_post[m_lane] = m_val % 32;
          end else m_val = model_param();
        end
      end else if (bus_wr) begin
        case (int'(bus_addr))
          8:  m_lane = int'(bus_wdata[7:0]);
          9:  m_port = int'(bus_wdata[7:0]);
          11: m_sel  = int'(bus_wdata[5:0]);
          12: m_val  = int'(bus_wdata[6:0]);
          10: if (bus_wdata[1:0] != 2'b00) begin
                if (m_lane >= 4 || m_port >= 2 || m_sel > 2) m_err = 1;
                else begin
                  m_err = 0; m_busy = 1; m_left = 4;
                  m_store = bus_wdata[0] ? 1 : 0;
                end
              end
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model (R2 register view)
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      vectors++;
      if (bus_rdata !== 32'(model_read(int'(bus_addr)))) begin
        fails++;
        $display("FAIL R2 model compare addr=%0h actual=%0h expected=%0h",
                 bus_addr, bus_rdata, model_read(int'(bus_addr)));
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rreg(logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 20; k++) begin
      rreg(7'h0A, s);
      if (!s[8]) return;
    end
  endtask

  task automatic setup(int lane, int port, int sel);
    wreg(7'h08, lane); wreg(7'h09, port); wreg(7'h0B, sel);
  endtask

  task automatic store(int lane, int sel, int val);
    setup(lane, 0, sel); wreg(7'h0C, val); wreg(7'h0A, 32'h1); wait_idle();
  endtask

  task automatic fetch(int lane, int sel, output logic [31:0] v);
    setup(lane, 0, sel); wreg(7'h0A, 32'h2); wait_idle(); rreg(7'h0C, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 8; a <= 12; a++) begin rreg(7'(a), v); chk("R1 reset register", v, 0); end
    fetch(3, 2, v); chk("R1 reset parameter", v, 0);

    // R2 unmapped and undefined bits
    wreg(7'h20, 32'hFFFF_FFFF); rreg(7'h20, v); chk("R2 unmapped reads zero", v, 0);
    wreg(7'h0C, 32'hFFFF_FFFF); rreg(7'h0C, v); chk("R2 staging width", v, 32'h7F);
    wreg(7'h0B, 32'hFFFF_FFC0); rreg(7'h0B, v); chk("R2 selector width", v, 0);

    // R4 busy window
    setup(1, 1, 0); wreg(7'h0C, 32'h7F);
    @(negedge clk); bus_addr = 7'h0A; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    for (int c = 0; c < 4; c++) begin #1; chk("R4 busy high", {31'b0, bus_rdata[8]}, 1); @(negedge clk); end
    #1; chk("R4 busy low after window", {31'b0, bus_rdata[8]}, 0);

    // R7, R10 swing store drops bit 6; fetch zero-extends
    fetch(1, 0, v); chk("R7 R10 swing fetch", v, 32'h3F);

    // R8 pre-cursor codes, two zeros
    store(2, 1, 32'h10); fetch(2, 1, v); chk("R8 negative-zero code kept", v, 32'h10);
    store(2, 1, 32'h00); fetch(2, 1, v); chk("R8 positive-zero code", v, 0);
    store(2, 1, 32'h7F); fetch(2, 1, v); chk("R8 upper bits ignored", v, 32'h1F);
    store(2, 1, 32'h05); fetch(2, 1, v); chk("R8 magnitude code", v, 32'h05);

    // R9 post-cursor
    store(0, 2, 32'h1F); fetch(0, 2, v); chk("R9 post max", v, 32'h1F);

    // R11 lanes independent
    store(3, 2, 32'h0A); fetch(0, 2, v); chk("R11 lane 0 untouched", v, 32'h1F);
    fetch(3, 2, v); chk("R11 lane 3 own value", v, 32'h0A);

    // R5 rejection paths
    setup(4, 0, 0); wreg(7'h0C, 5); wreg(7'h0A, 32'h1); rreg(7'h0A, v);
    chk("R5 bad lane error", v, 32'h200);
    setup(1, 2, 0); wreg(7'h0A, 32'h1); rreg(7'h0A, v); chk("R5 bad port error", v, 32'h200);
    setup(1, 0, 3); wreg(7'h0A, 32'h2); rreg(7'h0A, v); chk("R5 bad selector error", v, 32'h200);
    fetch(1, 0, v); chk("R5 error cleared and value kept", v, 32'h3F);
    rreg(7'h0A, v); chk("R5 error clear", v, 0);

    // R3 both command bits: store wins
    setup(0, 0, 0); wreg(7'h0C, 32'h15); wreg(7'h0A, 32'h3); wait_idle();
    wreg(7'h0C, 0); fetch(0, 0, v); chk("R3 store wins", v, 32'h15);

    // R6 accesses during busy ignored
    setup(2, 0, 2); wreg(7'h0C, 32'h07);
    @(negedge clk); bus_addr = 7'h0A; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_addr = 7'h0C; bus_wdata = 32'h11;
    @(negedge clk); bus_addr = 7'h0A; bus_wdata = 32'h2;
    @(negedge clk); bus_addr = 7'h0B; bus_wdata = 32'h0;
    @(negedge clk); bus_wr = 1'b0;
    wait_idle();
    rreg(7'h0C, v); chk("R6 staging unchanged during busy", v, 32'h07);
    rreg(7'h0B, v); chk("R6 selector unchanged during busy", v, 2);
    fetch(2, 2, v); chk("R6 store used original value", v, 32'h07);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule